// File: doc/BRIEF.md
# Transmit Descriptor Chain DMA Engine

This engine drains a linked list of transmit descriptors held in system memory. Software stores each packet in a buffer. It describes the packet with a three-word descriptor, loads the address of the first descriptor, then writes the control register with its enable bit set. The engine reads each descriptor and fetches the packet bytes one 32-bit word at a time. It hands the bytes out on a byte stream that carries first-byte and last-byte markers. It then writes the descriptor's size word back with the empty flag set, so software can see the slot has been consumed, and follows the next pointer.

The walk ends at the first descriptor whose empty flag is already set. At that point the engine pulses an underrun event and clears its own enable bit. A loopback select, sampled at the start of every packet, sends that packet's bytes to a second stream that feeds the receive path instead of the transmit output. Every stream transfer uses a valid/ready handshake, so a slow consumer stalls the engine and no byte is lost.

Top module: `txd_dma`

## Requirements
- R1: After reset `busy`, `dma_en`, `mem_req`, `tx_valid` and `lb_valid` are low. A write of the control offset (0x180) with bit 0 set while idle, with `mac_tx_en` high, sets `dma_en` and `busy` and starts memory reads at the descriptor start address.
- R2: A start write while `mac_tx_en` is low sets `dma_en` but leaves `busy` low and issues no memory request. A later idle write of 0 to the control offset clears `dma_en`.
- R3: Writes to the descriptor start offset (0x184) store the address with bits 1:0 forced to zero. Next pointers are aligned the same way. A descriptor is read as word 0 = buffer address at +0, word 1 = size/flag word at +4 and word 2 = next descriptor address at +8, in that order. Every memory address is word aligned.
- R4: In the size word, bit 31 is the empty flag and bits 10:0 are the packet length; bits 30:11 are ignored. Bytes are taken little-endian from consecutive buffer addresses, starting at any byte offset of the buffer address.
- R5: `st_sof` marks the first byte and `st_eof` the last byte of each packet. A descriptor of length zero emits no byte but is still written back and counted.
- R6: After the last byte of a packet, the engine writes the original size word with bit 31 set to descriptor +4. It then pulses `evt_sent` and continues at the next pointer.
- R7: A descriptor whose size word has bit 31 set produces one `evt_underrun` pulse. It causes no memory write and emits no byte. `busy` drops with the pulse and `dma_en` clears on the following cycle.
- R8: Writes to the control offset while a walk is in progress are ignored: `dma_en` stays set and the walk continues unchanged.
- R9: When `loop_sel` is high at the start of a packet, all its bytes leave on the `lb_*` handshake and `tx_valid` stays low. The two valids are never high together.
- R10: While a valid is high and its ready is low, the valid, `st_data`, `st_sof` and `st_eof` hold. The byte sequence is unchanged by stalls.
- R11: `mem_req` stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | CSR_AW | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| mac_tx_en | input | 1 | MAC transmit enable, sampled at start |
| loop_sel | input | 1 | Loopback select, sampled per packet |
| dma_en | output | 1 | Control register enable bit |
| busy | output | 1 | Descriptor walk in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, read data valid |
| mem_rdata | input | 32 | Memory read data |
| st_data | output | 8 | Stream byte, shared by both streams |
| st_sof | output | 1 | First byte of packet |
| st_eof | output | 1 | Last byte of packet |
| tx_valid | output | 1 | Transmit stream valid |
| tx_ready | input | 1 | Transmit stream ready |
| lb_valid | output | 1 | Loopback stream valid |
| lb_ready | input | 1 | Loopback stream ready |
| evt_sent | output | 1 | One-cycle pulse per completed descriptor |
| evt_underrun | output | 1 | One-cycle pulse on reaching an empty descriptor |

## Verification
The bench drives a packet whose buffer starts at an odd byte address. A design that ignored the offset would emit the wrong leading bytes. Size words carry junk in bits 30:11 and next pointers carry set low bits: wrong masking would give oversized packets, or a walk through misaligned or garbage descriptors. A zero-length descriptor checks the write-back without any output; an engine that decremented first would send about two thousand bytes. A chain whose first slot is empty must yield an underrun with no write. Start writes made during a slow, stalled walk must not restart it or clear the enable, and loopback packets must never appear on the transmit stream.

// File: rtl/txd_pkg.sv
package txd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DBUF,
      ST_DSIZE,
      ST_DNEXT,
      ST_FETCH,
      ST_EMIT,
      ST_WBACK
   } walk_st_t;

   localparam int unsigned OWN_BIT = 31;
   localparam int unsigned LANES   = 4;
endpackage

// File: rtl/txd_csr.sv
module txd_csr #(
   parameter int              CSR_AW   = 12,
   parameter logic [CSR_AW-1:0] CTL_OFS  = CSR_AW'('h180),
   parameter logic [CSR_AW-1:0] DESC_OFS = CSR_AW'('h184)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_wr,
   input  logic [CSR_AW-1:0] csr_addr,
   input  logic [31:0]       csr_wdata,
   input  logic              mac_tx_en,
   input  logic              busy,
   input  logic              stop,
   output logic              dma_en,
   output logic [31:0]       desc_base,
   output logic              start
);
   if (CTL_OFS == DESC_OFS || CTL_OFS[1:0] != 2'b00 || DESC_OFS[1:0] != 2'b00)
   begin : g_bad_ofs
      $error("txd_csr: register offsets must differ and be word aligned");
   end

   logic ctl_hit, desc_hit, locked;

   assign ctl_hit  = csr_wr && (csr_addr == CTL_OFS);
   assign desc_hit = csr_wr && (csr_addr == DESC_OFS);
   assign locked   = busy | start | stop;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dma_en    <= 1'b0;
         desc_base <= '0;
         start     <= 1'b0;
      end else begin
         start <= 1'b0;
         if (stop) begin
            dma_en <= 1'b0;
         end else if (ctl_hit && !locked) begin
            dma_en <= csr_wdata[0];
            start  <= csr_wdata[0] & mac_tx_en;
         end
         if (desc_hit) begin
            desc_base <= {csr_wdata[31:2], 2'b00};
         end
      end
   end
endmodule

// File: rtl/txd_seq.sv
module txd_seq
   import txd_pkg::*;
#(
   parameter int LEN_W = 11
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic [31:0] desc_base,
   input  logic        loop_sel,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic        mem_ack,
   input  logic [31:0] mem_rdata,
   output logic        out_valid,
   output logic [7:0]  out_data,
   output logic        out_sof,
   output logic        out_eof,
   output logic        out_loop,
   input  logic        out_ready,
   output logic        busy,
   output logic        evt_sent,
   output logic        evt_underrun
);
   if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
      $error("txd_seq: LEN_W must lie in 1..16");
   end

   localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);
   localparam logic [31:0]      OWN_MASK = 32'h1 << OWN_BIT;

   walk_st_t          st;
   logic [31:0]       cur, buf_ptr, nxt, size_w, word;
   logic [LEN_W-1:0]  remain;
   logic [1:0]        lane;
   logic              first, loop_q;
   logic [7:0]        lane_byte [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_byte[g] = word[8*g +: 8];
   end

   always_comb begin
      mem_req  = 1'b1;
      mem_we   = 1'b0;
      mem_addr = '0;
      unique case (st)
         ST_DBUF:  mem_addr = cur;
         ST_DSIZE: mem_addr = cur + 32'd4;
         ST_DNEXT: mem_addr = cur + 32'd8;
         ST_FETCH: mem_addr = buf_ptr;
         ST_WBACK: begin
            mem_addr = cur + 32'd4;
            mem_we   = 1'b1;
         end
         default:  mem_req = 1'b0;
      endcase
   end

   assign mem_wdata = size_w | OWN_MASK;
   assign busy      = (st != ST_IDLE);
   assign out_valid = (st == ST_EMIT);
   assign out_data  = lane_byte[lane];
   assign out_sof   = out_valid & first;
   assign out_eof   = out_valid & (remain == LEN_ONE);
   assign out_loop  = loop_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st           <= ST_IDLE;
         cur          <= '0;
         buf_ptr      <= '0;
         nxt          <= '0;
         size_w       <= '0;
         word         <= '0;
         remain       <= '0;
         lane         <= '0;
         first        <= 1'b0;
         loop_q       <= 1'b0;
         evt_sent     <= 1'b0;
         evt_underrun <= 1'b0;
      end else begin
         evt_sent     <= 1'b0;
         evt_underrun <= 1'b0;
         unique case (st)
            ST_IDLE: if (start) begin
               cur <= desc_base;
               st  <= ST_DBUF;
            end
            ST_DBUF: if (mem_ack) begin
               buf_ptr <= {mem_rdata[31:2], 2'b00};
               lane    <= mem_rdata[1:0];
               st      <= ST_DSIZE;
            end
            ST_DSIZE: if (mem_ack) begin
               size_w <= mem_rdata;
               remain <= mem_rdata[LEN_W-1:0];
               if (mem_rdata[OWN_BIT]) begin
                  evt_underrun <= 1'b1;
                  st           <= ST_IDLE;
               end else begin
                  st <= ST_DNEXT;
               end
            end
            ST_DNEXT: if (mem_ack) begin
               nxt    <= {mem_rdata[31:2], 2'b00};
               loop_q <= loop_sel;
               first  <= 1'b1;
               st     <= (remain == '0) ? ST_WBACK : ST_FETCH;
            end
            ST_FETCH: if (mem_ack) begin
               word <= mem_rdata;
               st   <= ST_EMIT;
            end
            ST_EMIT: if (out_ready) begin
               first  <= 1'b0;
               remain <= remain - LEN_ONE;
               lane   <= lane + 2'd1;
               if (remain == LEN_ONE) begin
                  st <= ST_WBACK;
               end else if (lane == 2'd3) begin
                  buf_ptr <= buf_ptr + 32'd4;
                  st      <= ST_FETCH;
               end
            end
            ST_WBACK: if (mem_ack) begin
               evt_sent <= 1'b1;
               cur      <= nxt;
               st       <= ST_DBUF;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/txd_steer.sv
module txd_steer #(
   parameter bit LOOPBACK_EN = 1'b1
) (
   input  logic out_valid,
   input  logic out_loop,
   output logic out_ready,
   output logic tx_valid,
   input  logic tx_ready,
   output logic lb_valid,
   input  logic lb_ready
);
   if (LOOPBACK_EN) begin : g_loop
      assign tx_valid  = out_valid & ~out_loop;
      assign lb_valid  = out_valid &  out_loop;
      assign out_ready = out_loop ? lb_ready : tx_ready;
   end else begin : g_noloop
      logic unused_lb;
      assign unused_lb = lb_ready ^ out_loop;
      assign tx_valid  = out_valid;
      assign lb_valid  = 1'b0;
      assign out_ready = tx_ready;
   end
endmodule

// File: rtl/txd_dma.sv
module txd_dma #(
   parameter int                CSR_AW      = 12,
   parameter logic [CSR_AW-1:0] CTL_OFS     = CSR_AW'('h180),
   parameter logic [CSR_AW-1:0] DESC_OFS    = CSR_AW'('h184),
   parameter int                LEN_W       = 11,
   parameter bit                LOOPBACK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_wr,
   input  logic [CSR_AW-1:0] csr_addr,
   input  logic [31:0]       csr_wdata,
   input  logic              mac_tx_en,
   input  logic              loop_sel,
   output logic              dma_en,
   output logic              busy,
   output logic              mem_req,
   output logic              mem_we,
   output logic [31:0]       mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic [7:0]        st_data,
   output logic              st_sof,
   output logic              st_eof,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic              lb_valid,
   input  logic              lb_ready,
   output logic              evt_sent,
   output logic              evt_underrun
);
   if (CSR_AW < 9 || CSR_AW > 32) begin : g_bad_aw
      $error("txd_dma: CSR_AW must lie in 9..32");
   end

   logic [31:0] desc_base;
   logic        start, out_valid, out_loop, out_ready;

   txd_csr #(
      .CSR_AW   (CSR_AW),
      .CTL_OFS  (CTL_OFS),
      .DESC_OFS (DESC_OFS)
   ) u_csr (
      .clk       (clk),
      .rst_n     (rst_n),
      .csr_wr    (csr_wr),
      .csr_addr  (csr_addr),
      .csr_wdata (csr_wdata),
      .mac_tx_en (mac_tx_en),
      .busy      (busy),
      .stop      (evt_underrun),
      .dma_en    (dma_en),
      .desc_base (desc_base),
      .start     (start)
   );

   txd_seq #(
      .LEN_W (LEN_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .desc_base    (desc_base),
      .loop_sel     (loop_sel),
      .mem_req      (mem_req),
      .mem_we       (mem_we),
      .mem_addr     (mem_addr),
      .mem_wdata    (mem_wdata),
      .mem_ack      (mem_ack),
      .mem_rdata    (mem_rdata),
      .out_valid    (out_valid),
      .out_data     (st_data),
      .out_sof      (st_sof),
      .out_eof      (st_eof),
      .out_loop     (out_loop),
      .out_ready    (out_ready),
      .busy         (busy),
      .evt_sent     (evt_sent),
      .evt_underrun (evt_underrun)
   );

   txd_steer #(
      .LOOPBACK_EN (LOOPBACK_EN)
   ) u_steer (
      .out_valid (out_valid),
      .out_loop  (out_loop),
      .out_ready (out_ready),
      .tx_valid  (tx_valid),
      .tx_ready  (tx_ready),
      .lb_valid  (lb_valid),
      .lb_ready  (lb_ready)
   );
endmodule

// File: rtl/txd_dma_chk.sv
module txd_dma_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        dma_en,
   input logic        busy,
   input logic        mem_req,
   input logic        mem_we,
   input logic [31:0] mem_addr,
   input logic [31:0] mem_wdata,
   input logic        mem_ack,
   input logic [7:0]  st_data,
   input logic        st_sof,
   input logic        st_eof,
   input logic        tx_valid,
   input logic        tx_ready,
   input logic        lb_valid,
   input logic        lb_ready,
   input logic        evt_sent,
   input logic        evt_underrun
);
   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req && !tx_valid && !lb_valid);

   assert_word_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[1:0] == 2'b00);

   assert_sent_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_sent |-> $past(mem_req && mem_we && mem_ack));

   assert_underrun_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      evt_underrun |-> !busy && !evt_sent);

   assert_underrun_clears_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
      evt_underrun |=> !dma_en);

   assert_one_dest_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_valid && lb_valid));

   assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(st_data) && $stable(st_sof) && $stable(st_eof));

   assert_lb_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lb_valid && !lb_ready |=> lb_valid && $stable(st_data) && $stable(st_sof) && $stable(st_eof));

   assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
endmodule

bind txd_dma txd_dma_chk u_chk (.*);

// File: tb/sim_txd_dma.sv
`timescale 1ns/1ps
module sim_txd_dma;
   localparam logic [11:0] CTL  = 12'h180;
   localparam logic [11:0] DESC = 12'h184;

   logic clk = 1'b0, rst_n = 1'b0;
   logic csr_wr = 1'b0;
   logic [11:0] csr_addr = '0;
   logic [31:0] csr_wdata = '0;
   logic mac_tx_en = 1'b0, loop_sel = 1'b0;
   logic dma_en, busy, mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [7:0] st_data;
   logic st_sof, st_eof, tx_valid, lb_valid, evt_sent, evt_underrun;
   logic tx_ready = 1'b1, lb_ready = 1'b1;

   always #2 clk = ~clk;

   txd_dma u0 (.*);

   int checks = 0, errors = 0;

   // memory model
   logic [31:0] mem [0:255];
   int lat = 0, mcnt = 0;
   logic ack_r = 1'b0;
   logic [31:0] rdata_r = '0;
   logic bd_we = 1'b0;
   logic [7:0] bd_idx = '0;
   logic [31:0] bd_data = '0;
   logic [31:0] acc_addr [0:511];
   logic acc_we [0:511];
   int acc_n = 0;
   assign mem_ack = ack_r;
   assign mem_rdata = rdata_r;

   always @(posedge clk) begin
      if (bd_we) mem[bd_idx] <= bd_data;
      if (!rst_n) begin
         ack_r <= 1'b0; mcnt <= 0;
      end else if (ack_r) begin
         ack_r <= 1'b0; mcnt <= 0;
      end else if (mem_req) begin
         if (mcnt >= lat) begin
            ack_r <= 1'b1;
            rdata_r <= mem[mem_addr[9:2]];
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            acc_addr[acc_n % 512] <= mem_addr;
            acc_we[acc_n % 512] <= mem_we;
            acc_n <= acc_n + 1;
         end else begin
            mcnt <= mcnt + 1;
         end
      end
   end

   // stream collector and monitors
   logic [7:0] cap_data [0:255];
   logic cap_sof [0:255], cap_eof [0:255], cap_lb [0:255];
   int cap_n = 0, sent_n = 0, und_n = 0, txv_n = 0, viol_st = 0, viol_mem = 0;
   logic p_v = 1'b0, p_rdy = 1'b0, p_req = 1'b0, p_ack = 1'b0;
   logic [7:0] p_data = '0;
   logic [31:0] p_addr = '0;

   always @(posedge clk) begin
      if (rst_n) begin
         if ((tx_valid && tx_ready) || (lb_valid && lb_ready)) begin
            cap_data[cap_n % 256] <= st_data;
            cap_sof[cap_n % 256]  <= st_sof;
            cap_eof[cap_n % 256]  <= st_eof;
            cap_lb[cap_n % 256]   <= lb_valid;
            cap_n <= cap_n + 1;
         end
         if (tx_valid) txv_n <= txv_n + 1;
         if (evt_sent) sent_n <= sent_n + 1;
         if (evt_underrun) und_n <= und_n + 1;
         if (p_v && !p_rdy && (!(tx_valid || lb_valid) || st_data != p_data)) viol_st <= viol_st + 1;
         if (p_req && !p_ack && (!mem_req || mem_addr != p_addr)) viol_mem <= viol_mem + 1;
         p_v    <= tx_valid | lb_valid;
         p_rdy  <= (tx_valid & tx_ready) | (lb_valid & lb_ready);
         p_data <= st_data;
         p_req  <= mem_req;
         p_ack  <= mem_ack;
         p_addr <= mem_addr;
      end
   end

   bit stall = 1'b0;
   int cyc = 0;
   always @(negedge clk) begin
      cyc = cyc + 1;
      tx_ready = stall ? (cyc % 3 != 0) : 1'b1;
      lb_ready = stall ? (cyc % 4 != 1) : 1'b1;
   end

   function automatic logic [7:0] byte_at(int a);
      return 8'((a * 7 + 3) & 255);
   endfunction

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic csr_write(logic [11:0] a, logic [31:0] d);
      csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
      @(negedge clk);
      csr_wr = 1'b0;
   endtask

   task automatic poke(int a, logic [31:0] d);
      bd_we = 1'b1; bd_idx = 8'(a >> 2); bd_data = d;
      @(negedge clk);
      bd_we = 1'b0;
   endtask

   task automatic fill_mem();
      for (int i = 0; i < 256; i++)
         poke(i * 4, {byte_at(4*i+3), byte_at(4*i+2), byte_at(4*i+1), byte_at(4*i)});
   endtask

   task automatic put_desc(int at, logic [31:0] b, logic [31:0] s, logic [31:0] n);
      poke(at, b); poke(at + 4, s); poke(at + 8, n);
   endtask

   task automatic run_chain();
      csr_write(CTL, 32'h1);
      for (int i = 0; i < 10 && !busy; i++) @(negedge clk);
      for (int i = 0; i < 50000 && busy; i++) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic chk_pkt(int base, int a, int len, bit lb, string tag);
      int bad = 0;
      for (int k = 0; k < len; k++) begin
         if (cap_data[(base+k) % 256] != byte_at(a + k)) bad++;
         if (cap_sof[(base+k) % 256] != (k == 0)) bad++;
         if (cap_eof[(base+k) % 256] != (k == len - 1)) bad++;
         if (cap_lb[(base+k) % 256] != lb) bad++;
      end
      chk(bad == 0, tag, bad, 0);
   endtask

   task automatic t_reset();
      chk(!busy && !dma_en, "R1 reset busy/dma_en", {busy, dma_en}, 0);
      chk(!mem_req && !tx_valid && !lb_valid, "R1 reset outputs", {mem_req, tx_valid, lb_valid}, 0);
   endtask

   task automatic t_txoff();
      int a0 = acc_n;
      mac_tx_en = 1'b0;
      csr_write(CTL, 32'h1);
      repeat (20) @(negedge clk);
      chk(dma_en == 1'b1, "R2 enable bit set", dma_en, 1);
      chk(busy == 1'b0, "R2 no walk without tx enable", busy, 0);
      chk(acc_n == a0, "R2 no memory access", acc_n - a0, 0);
      csr_write(CTL, 32'h0);
      @(negedge clk);
      chk(dma_en == 1'b0, "R2 idle write clears enable", dma_en, 0);
   endtask

   task automatic t_basic();
      int a0, c0, s0, u0n, wr;
      mac_tx_en = 1'b1; loop_sel = 1'b0; stall = 1'b0; lat = 0;
      put_desc(32'h100, 32'h200, 32'h0000_F805, 32'h113);
      put_desc(32'h110, 32'h301, 32'h6, 32'h120);
      put_desc(32'h120, 32'h0, 32'h8000_0000, 32'h0);
      csr_write(DESC, 32'h103);
      a0 = acc_n; c0 = cap_n; s0 = sent_n; u0n = und_n;
      run_chain();
      chk(acc_n > a0, "R1 start issued reads", acc_n - a0, 1);
      chk(acc_addr[a0] == 32'h100 && acc_addr[a0+1] == 32'h104 && acc_addr[a0+2] == 32'h108,
          "R3 descriptor word order", acc_addr[a0], 32'h100);
      chk(cap_n - c0 == 11, "R4 byte count, upper size bits ignored", cap_n - c0, 11);
      chk_pkt(c0, 32'h200, 5, 1'b0, "R4 R5 aligned packet bytes/markers");
      chk_pkt(c0 + 5, 32'h301, 6, 1'b0, "R4 R5 unaligned packet bytes/markers");
      chk(mem[8'h41] == 32'h8000_F805, "R6 writeback desc0", mem[8'h41], 32'h8000_F805);
      chk(mem[8'h45] == 32'h8000_0006, "R6 writeback desc1 via aligned next (R3)", mem[8'h45], 32'h8000_0006);
      chk(sent_n - s0 == 2, "R6 sent pulses", sent_n - s0, 2);
      chk(und_n - u0n == 1, "R7 underrun pulse", und_n - u0n, 1);
      chk(dma_en == 1'b0 && busy == 1'b0, "R7 enable self-cleared", {dma_en, busy}, 0);
      wr = 0;
      for (int i = a0; i < acc_n; i++) if (acc_we[i % 512]) wr++;
      chk(wr == 2, "R7 no write to empty descriptor", wr, 2);
   endtask

   task automatic t_empty_first();
      int a0, c0, s0, u0n;
      put_desc(32'h140, 32'h200, 32'h8000_0003, 32'h100);
      csr_write(DESC, 32'h140);
      a0 = acc_n; c0 = cap_n; s0 = sent_n; u0n = und_n;
      run_chain();
      chk(acc_n - a0 == 2, "R7 only two reads on empty head", acc_n - a0, 2);
      chk(cap_n == c0 && sent_n == s0, "R7 nothing sent", cap_n - c0, 0);
      chk(und_n - u0n == 1 && !dma_en, "R7 underrun and enable clear", und_n - u0n, 1);
   endtask

   task automatic t_busy_stall();
      int c0, s0;
      lat = 3; stall = 1'b1;
      put_desc(32'h180, 32'h204, 32'h0, 32'h190);
      put_desc(32'h190, 32'h202, 32'h9, 32'h1A0);
      put_desc(32'h1A0, 32'h0, 32'h8000_0000, 32'h0);
      csr_write(DESC, 32'h180);
      c0 = cap_n; s0 = sent_n;
      csr_write(CTL, 32'h1);
      for (int i = 0; i < 10 && !busy; i++) @(negedge clk);
      csr_write(CTL, 32'h0);
      csr_write(CTL, 32'h1);
      chk(dma_en == 1'b1 && busy == 1'b1, "R8 writes while busy ignored", {dma_en, busy}, 3);
      for (int i = 0; i < 50000 && busy; i++) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(cap_n - c0 == 9, "R5 zero length emits nothing", cap_n - c0, 9);
      chk_pkt(c0, 32'h202, 9, 1'b0, "R10 bytes intact under stalls");
      chk(mem[8'h61] == 32'h8000_0000, "R5 zero length written back", mem[8'h61], 32'h8000_0000);
      chk(sent_n - s0 == 2, "R8 walk ran once", sent_n - s0, 2);
      chk(viol_st == 0, "R10 stream held while stalled", viol_st, 0);
      chk(viol_mem == 0, "R11 request held until ack", viol_mem, 0);
      lat = 0;
   endtask

   task automatic t_loop();
      int c0, t0;
      loop_sel = 1'b1; stall = 1'b1;
      put_desc(32'h1C0, 32'h220, 32'h7, 32'h1D0);
      put_desc(32'h1D0, 32'h0, 32'h8000_0000, 32'h0);
      csr_write(DESC, 32'h1C0);
      c0 = cap_n; t0 = txv_n;
      run_chain();
      chk(cap_n - c0 == 7, "R9 loopback byte count", cap_n - c0, 7);
      chk_pkt(c0, 32'h220, 7, 1'b1, "R9 loopback bytes on lb stream");
      chk(txv_n == t0, "R9 transmit stream silent", txv_n - t0, 0);
      loop_sel = 1'b0; stall = 1'b0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      fill_mem();
      t_txoff();
      t_basic();
      t_empty_first();
      t_busy_stall();
      t_loop();
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      finish_run();
   end
endmodule